// File: doc/BRIEF.md
# Receiver PHY bring-up sequencer

This block powers a receiver PHY up and down on command. A power-on command carries the lane rate in Mbps. The block maps that rate to a 7-bit band code and a 10-bit oscillator target, using a built-in table of 63 bands that spans 80 to 2500 Mbps. It then walks a fixed ordered program. The program first moves the PHY's reset, shutdown and test-clear levels. It next sets the configuration clock band, then makes seven indirect register writes through a bit-banged test port (strobe, enable, 8-bit data). Last, it moves the lane control levels and releases the PHY. A power-off command only drops reset and then shutdown.

Commands arrive on a valid/ready handshake. The rate and step length are sampled with `cmd_valid` on the edge where `cmd_ready` is high. `cmd_ready` is low for the whole of a running sequence, so the requester must hold `cmd_valid` and its payload until it is accepted. The outputs have no back-pressure. Each program step holds its levels for a programmable number of clocks, so a slower target can resample every level it sees.

Top module: `phyup_seq`

## Requirements
- R1: After reset: `cmd_ready`=1. `busy`, `done`, `err`, `tp_strobe`, `tp_enable`, `tp_clear`, `phy_rst_n`, `phy_shutdown_n`, `phy_base_dir` and `phy_clk_en` are all 0. `tp_data`, `phy_force_rx` and `phy_cfgclk_range` are all zero.
- R2: Power-on picks the first table band whose rate is at least the request and writes that band's code to test address 0x002. Example bands: 80→0x00, 90→0x10, 1000→0x0A, 1050→0x1A, 1110→0x2A, 1500→0x2C, 1550→0x3D, 2000→0x0F, 2050→0x40, 2450→0x48, 2500→0x49.
- R3: The oscillator target is written as a low byte to 0x0E2 and a high byte to 0x0E3. The target is 460 for every band up to 1500 and for 2500. Between 1550 and 2450 it climbs from 285 to 451 (for example, 2000→368 and 2050→377).
- R4: Exactly seven writes are issued, in this order: 0x002=code, 0x001=0x20, 0x0E2, 0x0E3, 0x0E4=0x11, 0x0E1=0x01, 0x0E0=0x80.
- R5: Each write is carried by 16 single-signal level steps. The first strobe fall with enable high carries data 0x00. The next strobe rise with enable low carries the top 4 address bits (zero-extended). The next strobe fall with enable high carries the low 8 address bits. The next strobe rise with enable low carries the value. Strobe and enable never change on the same edge.
- R6: Every test-port level is held for at least max(2, `step_cycles`) clocks.
- R7: Power-on order: reset low, then shutdown low, then `tp_clear` pulses 0→1→0 while both are low, then `phy_cfgclk_range`=0x28, then the writes, then `phy_base_dir`=1, then `phy_clk_en`=1, then `phy_force_rx`=0, then shutdown high, and finally reset high.
- R8: Power-off ignores the rate. It drops `phy_rst_n` on the accepting edge and drops `phy_shutdown_n` max(2, `step_cycles`) clocks later, with no test-port activity.
- R9: A power-on whose rate is 0 or above 2500 is accepted. On that same edge it sets `err` and pulses `done`, and it changes no PHY or test-port output.
- R10: `busy` is high from the accepting edge until the edge of the last control change. `done` pulses for exactly one cycle on that edge. `cmd_ready` stays low while busy, so commands offered then are not taken.
- R11: `err` stays set until the next accepted command that is not rejected, and that command's accepting edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_power_on | input | 1 | 1 = power-on, 0 = power-off |
| cmd_rate_mbps | input | 12 | Requested lane rate in Mbps |
| step_cycles | input | HOLD_W | Clocks per program step (values below 2 act as 2) |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last power-on rate was out of range |
| tp_strobe | output | 1 | Test-port strobe |
| tp_enable | output | 1 | Test-port enable |
| tp_data | output | 8 | Test-port data |
| tp_clear | output | 1 | Test-port clear |
| phy_rst_n | output | 1 | PHY reset, active low |
| phy_shutdown_n | output | 1 | PHY shutdown, active low |
| phy_base_dir | output | 1 | Lane base direction |
| phy_clk_en | output | 1 | PHY clock enable |
| phy_force_rx | output | 4 | Force-receive mode field |
| phy_cfgclk_range | output | 6 | Configuration clock band |

## Verification
A rejected power-on shows `done` and `err` at the first falling-edge sample after the accepting edge. A power-off shows `busy` for exactly max(2, `step_cycles`) samples, and `phy_shutdown_n` drops that many cycles after `phy_rst_n`. A full power-on has no fixed length that the checks rely on. Its checks instead time-stamp every output change at the falling edge and compare the order of those stamps, the minimum distance between test-port changes, and the cycle of the `done` pulse against the cycle of the `phy_rst_n` release. Written values are recovered by a protocol decoder on the test-port pins.

// File: rtl/phyup_pkg.sv
`timescale 1ns/1ps
package phyup_pkg;
  localparam int RATE_W     = 12;
  localparam int CODE_W     = 7;
  localparam int OSC_W      = 10;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 12;
  localparam int NUM_RATES  = 63;
  localparam int NUM_WRITES = 7;
  localparam int CTRL_PRE   = 6;   // reset, shutdown, clear x3, cfg band
  localparam int CTRL_POST  = 5;   // base dir, clk en, force rx, shutdown, reset
  localparam int Q_W        = $clog2(CTRL_PRE + NUM_WRITES + CTRL_POST);
  localparam int Q_WR_FIRST = CTRL_PRE;
  localparam int Q_WR_LAST  = CTRL_PRE + NUM_WRITES - 1;
  localparam int Q_ON_LAST  = CTRL_PRE + NUM_WRITES + CTRL_POST - 1;
  localparam int Q_OFF_LAST = 1;
  localparam int FRX_W      = 4;
  localparam int CFG_W      = 6;
  localparam logic [CFG_W-1:0] CFG_BAND = 6'h28;
  localparam int WSTEP_W    = 4;   // 16 waveform steps per write

  localparam logic [CODE_W-1:0] LOW_CODES [0:52] = '{
    7'h00, 7'h10, 7'h20, 7'h30, 7'h01, 7'h11, 7'h21, 7'h31,
    7'h02, 7'h12, 7'h22, 7'h32, 7'h03, 7'h13, 7'h23, 7'h33,
    7'h04, 7'h14, 7'h25, 7'h35, 7'h05, 7'h16, 7'h26, 7'h37,
    7'h07, 7'h18, 7'h28, 7'h39, 7'h09, 7'h19, 7'h29, 7'h3A,
    7'h0A, 7'h1A, 7'h2A, 7'h3B, 7'h0B, 7'h1B, 7'h2B, 7'h3C,
    7'h0C, 7'h1C, 7'h2C, 7'h3D, 7'h0D, 7'h1D, 7'h2E, 7'h3E,
    7'h0E, 7'h1E, 7'h2F, 7'h3F, 7'h0F};

  localparam logic [OSC_W-1:0] HI_OSC [0:18] = '{
    10'd285, 10'd295, 10'd304, 10'd313, 10'd322, 10'd331, 10'd341,
    10'd350, 10'd359, 10'd368, 10'd377, 10'd387, 10'd396, 10'd405,
    10'd414, 10'd423, 10'd432, 10'd442, 10'd451};

  function automatic logic [RATE_W-1:0] rate_of(input int i);
    int r;
    if (i < 12)       r = 80 + 10 * i;
    else if (i < 16)  r = 205 + 15 * (i - 12);
    else if (i < 20)  r = 275 + 25 * (i - 16);
    else if (i < 34)  r = 400 + 50 * (i - 20);
    else if (i == 34) r = 1110;
    else              r = 1150 + 50 * (i - 35);
    return RATE_W'(r);
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input int i);
    if (i <= 52) return LOW_CODES[i];
    return CODE_W'(7'h40 + (i - 53));
  endfunction

  function automatic logic [OSC_W-1:0] osc_of(input int i);
    if (i <= 42 || i >= 62) return OSC_W'(460);
    return HI_OSC[i - 43];
  endfunction
endpackage

// File: rtl/phyup_rate_lookup.sv
`timescale 1ns/1ps
module phyup_rate_lookup
  import phyup_pkg::*;
(
  input  logic [RATE_W-1:0] rate,
  output logic [CODE_W-1:0] code,
  output logic [OSC_W-1:0]  osc,
  output logic              out_of_range
);
  int sel;

  always_comb begin
    sel = NUM_RATES - 1;
    for (int i = NUM_RATES - 2; i >= 0; i--) begin
      if (rate <= rate_of(i)) sel = i;
    end
    code = code_of(sel);
    osc  = osc_of(sel);
    out_of_range = (rate == '0) || (rate > rate_of(NUM_RATES - 1));
  end
endmodule

// File: rtl/phyup_tp_writer.sv
`timescale 1ns/1ps
module phyup_tp_writer
  import phyup_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] value,
  output logic              stb,
  output logic              en,
  output logic [DATA_W-1:0] data,
  output logic              wr_done
);
  localparam int HI_PAD = 2 * DATA_W - ADDR_W;

  logic               active;
  logic [WSTEP_W-1:0] step;
  logic [WSTEP_W-1:0] nstep;
  logic [HOLD_W-1:0]  hc;

  assign nstep = step + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      step    <= '0;
      hc      <= '0;
      stb     <= 1'b0;
      en      <= 1'b0;
      data    <= '0;
      wr_done <= 1'b0;
    end else begin
      wr_done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        step   <= '0;
        hc     <= hold - 1'b1;
        stb    <= 1'b0;
        en     <= 1'b0;
      end else if (active) begin
        if (hc != '0) begin
          hc <= hc - 1'b1;
        end else if (step == '1) begin
          active  <= 1'b0;
          wr_done <= 1'b1;
        end else begin
          step <= nstep;
          hc   <= hold - 1'b1;
          case (nstep)
            4'd1:  en   <= 1'b1;
            4'd2:  stb  <= 1'b1;
            4'd3:  data <= '0;
            4'd4:  stb  <= 1'b0;
            4'd5:  en   <= 1'b0;
            4'd6:  data <= {{HI_PAD{1'b0}}, addr[ADDR_W-1:DATA_W]};
            4'd7:  stb  <= 1'b1;
            4'd8:  stb  <= 1'b0;
            4'd9:  en   <= 1'b1;
            4'd10: stb  <= 1'b1;
            4'd11: data <= addr[DATA_W-1:0];
            4'd12: stb  <= 1'b0;
            4'd13: en   <= 1'b0;
            4'd14: data <= value;
            default: stb <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/phyup_seq.sv
`timescale 1ns/1ps
module phyup_seq
  import phyup_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_power_on,
  input  logic [RATE_W-1:0] cmd_rate_mbps,
  input  logic [HOLD_W-1:0] step_cycles,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              tp_strobe,
  output logic              tp_enable,
  output logic [DATA_W-1:0] tp_data,
  output logic              tp_clear,
  output logic              phy_rst_n,
  output logic              phy_shutdown_n,
  output logic              phy_base_dir,
  output logic              phy_clk_en,
  output logic [FRX_W-1:0]  phy_force_rx,
  output logic [CFG_W-1:0]  phy_cfgclk_range
);
  logic [CODE_W-1:0] lk_code;
  logic [OSC_W-1:0]  lk_osc;
  logic              lk_bad;
  logic [HOLD_W-1:0] hold_eff, hold_r, hc;
  logic [CODE_W-1:0] code_r;
  logic [OSC_W-1:0]  osc_r;
  logic [Q_W-1:0]    q, nq;
  logic [2:0]        widx;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_val;
  logic              mode_on, waiting, wr_start, wr_done;
  logic              is_wr_next, last_next, step_end;

  phyup_rate_lookup u_lookup (
    .rate(cmd_rate_mbps), .code(lk_code), .osc(lk_osc), .out_of_range(lk_bad));

  assign hold_eff   = (step_cycles < HOLD_W'(2)) ? HOLD_W'(2) : step_cycles;
  assign nq         = q + 1'b1;
  assign is_wr_next = (nq >= Q_W'(Q_WR_FIRST)) && (nq <= Q_W'(Q_WR_LAST));
  assign last_next  = mode_on ? (nq == Q_W'(Q_ON_LAST)) : (nq == Q_W'(Q_OFF_LAST));
  assign step_end   = busy && (waiting ? wr_done : (hc == '0));
  assign widx       = 3'(q - Q_W'(Q_WR_FIRST));
  assign cmd_ready  = !busy;

  always_comb begin
    case (widx)
      3'd0:    begin wr_addr = 12'h002; wr_val = {1'b0, code_r}; end
      3'd1:    begin wr_addr = 12'h001; wr_val = 8'h20; end
      3'd2:    begin wr_addr = 12'h0E2; wr_val = osc_r[7:0]; end
      3'd3:    begin wr_addr = 12'h0E3; wr_val = 8'(osc_r >> 8); end
      3'd4:    begin wr_addr = 12'h0E4; wr_val = 8'h11; end
      3'd5:    begin wr_addr = 12'h0E1; wr_val = 8'h01; end
      default: begin wr_addr = 12'h0E0; wr_val = 8'h80; end
    endcase
  end

  phyup_tp_writer #(.HOLD_W(HOLD_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .hold(hold_r),
    .addr(wr_addr), .value(wr_val),
    .stb(tp_strobe), .en(tp_enable), .data(tp_data), .wr_done(wr_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      mode_on <= 1'b0; waiting <= 1'b0; wr_start <= 1'b0;
      q <= '0; hc <= '0; hold_r <= HOLD_W'(2);
      code_r <= '0; osc_r <= '0;
      tp_clear <= 1'b0; phy_rst_n <= 1'b0; phy_shutdown_n <= 1'b0;
      phy_base_dir <= 1'b0; phy_clk_en <= 1'b0;
      phy_force_rx <= '0; phy_cfgclk_range <= '0;
    end else begin
      done     <= 1'b0;
      wr_start <= 1'b0;
      if (cmd_valid && !busy) begin
        if (cmd_power_on && lk_bad) begin
          err  <= 1'b1;
          done <= 1'b1;
        end else begin
          err       <= 1'b0;
          busy      <= 1'b1;
          mode_on   <= cmd_power_on;
          code_r    <= lk_code;
          osc_r     <= lk_osc;
          hold_r    <= hold_eff;
          hc        <= hold_eff - 1'b1;
          q         <= '0;
          waiting   <= 1'b0;
          phy_rst_n <= 1'b0;
        end
      end else if (busy) begin
        if (!waiting && hc != '0) hc <= hc - 1'b1;
        if (step_end) begin
          q       <= nq;
          hc      <= hold_r - 1'b1;
          waiting <= 1'b0;
          if (is_wr_next) begin
            wr_start <= 1'b1;
            waiting  <= 1'b1;
          end else if (mode_on) begin
            case (nq)
              Q_W'(1):  phy_shutdown_n   <= 1'b0;
              Q_W'(2):  tp_clear         <= 1'b0;
              Q_W'(3):  tp_clear         <= 1'b1;
              Q_W'(4):  tp_clear         <= 1'b0;
              Q_W'(5):  phy_cfgclk_range <= CFG_BAND;
              Q_W'(13): phy_base_dir     <= 1'b1;
              Q_W'(14): phy_clk_en       <= 1'b1;
              Q_W'(15): phy_force_rx     <= '0;
              Q_W'(16): phy_shutdown_n   <= 1'b1;
              default:  phy_rst_n        <= 1'b1;
            endcase
          end else begin
            phy_shutdown_n <= 1'b0;
          end
          if (last_next) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/phyup_seq_chk.sv
`timescale 1ns/1ps
module phyup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic err,
  input logic tp_strobe,
  input logic tp_enable,
  input logic tp_clear,
  input logic phy_rst_n,
  input logic phy_shutdown_n
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  a_r7_reset_released_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> (phy_shutdown_n && done));
  a_r7_clear_inside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tp_clear |-> (!phy_rst_n && !phy_shutdown_n));
  a_r4_port_used_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tp_enable |-> !phy_rst_n);
  a_r6_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tp_strobe) |=> $stable(tp_strobe));
  a_r6_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tp_enable) |=> $stable(tp_enable));
  a_r5_single_signal_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(tp_strobe) && !$stable(tp_enable)));
  a_r9_err_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind phyup_seq phyup_seq_chk u_chk (.*);

// File: tb/phyup_seq_test.sv
`timescale 1ns/1ps
module phyup_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_power_on = 1'b0;
  logic [11:0] cmd_rate_mbps = '0;
  logic [7:0] step_cycles = 8'd2;
  logic busy, done, err, tp_strobe, tp_enable, tp_clear;
  logic [7:0] tp_data;
  logic phy_rst_n, phy_shutdown_n, phy_base_dir, phy_clk_en;
  logic [3:0] phy_force_rx;
  logic [5:0] phy_cfgclk_range;

  phyup_seq uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // {rate, code, osc target, step_cycles}
  localparam logic [36:0] VEC [12] = '{
    {12'd80,   7'h00, 10'd460, 8'd2}, {12'd81,   7'h10, 10'd460, 8'd0},
    {12'd1000, 7'h0A, 10'd460, 8'd3}, {12'd1001, 7'h1A, 10'd460, 8'd2},
    {12'd1110, 7'h2A, 10'd460, 8'd1}, {12'd1500, 7'h2C, 10'd460, 8'd2},
    {12'd1501, 7'h3D, 10'd285, 8'd4}, {12'd1550, 7'h3D, 10'd285, 8'd2},
    {12'd2000, 7'h0F, 10'd368, 8'd3}, {12'd2050, 7'h40, 10'd377, 8'd2},
    {12'd2449, 7'h48, 10'd451, 8'd5}, {12'd2500, 7'h49, 10'd460, 8'd2}};

  // monitor state
  logic p_stb = 0, p_en = 0, p_clr = 0, p_rst = 0, p_shd = 0, p_bd = 0, p_ce = 0;
  logic [7:0] p_data = 0;
  logic [5:0] p_cfg = 0;
  int exp_hold = 2, last_chg = -1, hold_bad = 0, wave_bad = 0, dph = 0, nwr = 0;
  int wa [8], wv [8];
  int cur_lo = 0, cur_hi = 0;
  int t_clr_r, t_clr_f, t_cfg, t_en1, t_tp_last, t_bd, t_ce;
  int t_shd_r, t_rst_r, t_rst_f, t_shd_f, t_done;
  int acc = 0, busy_cnt = 0, ready_bad = 0;
  logic done_after = 0;
  logic summary_done = 0;

  always @(negedge clk) begin
    if (tp_strobe != p_stb || tp_enable != p_en || tp_data != p_data) begin
      if (last_chg >= 0 && (cyc - last_chg) < exp_hold) hold_bad++;
      last_chg = cyc;
      t_tp_last = cyc;
    end
    if (p_stb && !tp_strobe && tp_enable) begin
      if (dph == 0) begin if (tp_data != 8'h00) wave_bad++; dph = 1; end
      else if (dph == 2) begin cur_lo = tp_data; dph = 3; end
      else wave_bad++;
    end
    if (!p_stb && tp_strobe && !tp_enable) begin
      if (dph == 1) begin cur_hi = tp_data; dph = 2; end
      else if (dph == 3) begin
        if (nwr < 8) begin wa[nwr] = cur_hi * 256 + cur_lo; wv[nwr] = tp_data; end
        nwr++; dph = 0;
      end else wave_bad++;
    end
    if (tp_enable && !p_en && t_en1 < 0) t_en1 = cyc;
    if (tp_clear && !p_clr) t_clr_r = cyc;
    if (!tp_clear && p_clr) t_clr_f = cyc;
    if (phy_cfgclk_range != p_cfg) t_cfg = cyc;
    if (phy_base_dir && !p_bd) t_bd = cyc;
    if (phy_clk_en && !p_ce) t_ce = cyc;
    if (phy_shutdown_n && !p_shd) t_shd_r = cyc;
    if (!phy_shutdown_n && p_shd) t_shd_f = cyc;
    if (phy_rst_n && !p_rst) t_rst_r = cyc;
    if (!phy_rst_n && p_rst) t_rst_f = cyc;
    p_stb = tp_strobe; p_en = tp_enable; p_data = tp_data; p_clr = tp_clear;
    p_cfg = phy_cfgclk_range; p_bd = phy_base_dir; p_ce = phy_clk_en;
    p_shd = phy_shutdown_n; p_rst = phy_rst_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input logic on, input logic [11:0] rate, input logic [7:0] sc, input bit poke);
    @(negedge clk);
    nwr = 0; dph = 0; wave_bad = 0; hold_bad = 0; last_chg = -1;
    t_clr_r = -1; t_clr_f = -1; t_cfg = -1; t_en1 = -1; t_tp_last = -1; t_bd = -1;
    t_ce = -1; t_shd_r = -1; t_rst_r = -1; t_rst_f = -1; t_shd_f = -1; t_done = -1;
    exp_hold = (sc < 2) ? 2 : int'(sc);
    cmd_power_on = on; cmd_rate_mbps = rate; step_cycles = sc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; acc = cyc; busy_cnt = 0; ready_bad = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done) begin t_done = cyc; break; end
      if (busy) busy_cnt++;
      if (poke && k < 20) begin
        if (cmd_ready) ready_bad++;
        cmd_valid = 1'b1; cmd_power_on = 1'b0;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    done_after = done;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] rate; logic [6:0] code; logic [9:0] osc; logic [7:0] sc;
    bit ok;
    do_reset();
    // R1 reset state
    chk({cmd_ready, busy, done, err, tp_strobe, tp_enable, tp_data, tp_clear, phy_rst_n,
         phy_shutdown_n, phy_base_dir, phy_clk_en, phy_force_rx, phy_cfgclk_range} == (29'd1 << 28),
        "R1", {cmd_ready, busy, done, err}, 8);

    for (int v = 0; v < 12; v++) begin
      do_reset();
      {rate, code, osc, sc} = VEC[v];
      run(1'b1, rate, sc, 1'b0);
      chk(nwr >= 1 && wa[0] == 12'h002 && wv[0] == int'(code), "R2", wv[0], int'(code));
      chk(nwr >= 4 && wa[2] == 12'h0E2 && wa[3] == 12'h0E3 && (wv[3] * 256 + wv[2]) == int'(osc),
          "R3", wv[3] * 256 + wv[2], int'(osc));
      ok = nwr == 7 && wa[1] == 12'h001 && wv[1] == 8'h20 && wa[4] == 12'h0E4 && wv[4] == 8'h11
           && wa[5] == 12'h0E1 && wv[5] == 8'h01 && wa[6] == 12'h0E0 && wv[6] == 8'h80;
      chk(ok, "R4", nwr, 7);
      chk(wave_bad == 0, "R5", wave_bad, 0);
      chk(hold_bad == 0, "R6", hold_bad, 0);
      ok = t_clr_r >= 0 && t_clr_r < t_clr_f && t_clr_f < t_cfg && t_cfg < t_en1
           && t_en1 <= t_tp_last && t_tp_last < t_bd && t_bd < t_ce && t_ce < t_shd_r
           && t_shd_r < t_rst_r && phy_cfgclk_range == 6'h28 && phy_force_rx == 4'h0;
      chk(ok, "R7", t_rst_r, t_shd_r + exp_hold);
      chk(t_done == t_rst_r && busy_cnt > 0 && !done_after, "R10", t_done, t_rst_r);
    end

    // R8 power-off from the powered state, rate ignored
    run(1'b0, 12'd0, 8'd3, 1'b0);
    chk(t_rst_f == acc && t_shd_f == acc + 3 && t_done == t_shd_f, "R8", t_shd_f - t_rst_f, 3);
    chk(busy_cnt == 3 && nwr == 0 && t_tp_last == -1 && !phy_rst_n && !phy_shutdown_n && !err,
        "R8", busy_cnt, 3);

    // R10 commands offered while busy are not taken
    do_reset();
    run(1'b1, 12'd1000, 8'd2, 1'b1);
    chk(ready_bad == 0 && phy_rst_n && phy_shutdown_n && nwr == 7, "R10", ready_bad, 0);

    // R9 out-of-range power-on requests
    run(1'b1, 12'd0, 8'd2, 1'b0);
    chk(t_done == acc && err && busy_cnt == 0 && nwr == 0 && t_tp_last == -1 && phy_rst_n
        && t_rst_f == -1 && t_shd_f == -1, "R9", busy_cnt, 0);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R11", err, 1);
    run(1'b1, 12'd2501, 8'd2, 1'b0);
    chk(t_done == acc && err && busy_cnt == 0 && nwr == 0 && phy_rst_n && phy_shutdown_n,
        "R9", busy_cnt, 0);
    // R11 next good command clears err
    run(1'b0, 12'd0, 8'd2, 1'b0);
    chk(!err && t_rst_f == acc && t_shd_f == acc + 2, "R11", err, 0);

    summary_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule